// File: doc/BRIEF.md
# Flash Write Bus Latch

This block sits between the pins of a flash-style host bus and a command decoder. It watches the active-low chip enable, write enable, output enable and address-valid strobes plus the host bus clock, and reduces each completed host write to a single one-cycle transaction: a strobe with the address and the data for that write. It samples every pin with a fast internal clock. Every pin, including the address and data lines, passes through the same synchronizer chain, so the control edges and the bus values stay aligned.

A configuration input picks between two modes. In asynchronous mode, the address is taken when the later of the enable and write-enable falling edges arrives, and the host bus clock and address-valid pins have no effect. In synchronous mode, the block also accepts an address phase: a rising host bus clock edge, with address-valid and enable low and output enable high, latches the address for the next write. Plain asynchronous writes still work in this mode. In both modes, the data is the value present on the bus when the first of the enable and write-enable rising edges arrives. A bus cycle that has output enable low is never taken as a write.

Top module: `flash_wr_latch`

## Requirements
- R1: During and just after reset, `wr_valid` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: In an asynchronous write, `wr_addr` carries the bus address present when the second of the two strobes (`bus_ce_n`, `bus_we_n`) goes low, with `bus_oe_n` high. An address change between the two falling edges is reflected.
- R3: `wr_data` carries the bus data present just before the first of `bus_ce_n` and `bus_we_n` rises. Data changed after that edge is not taken.
- R4: Each completed write produces exactly one `wr_valid` pulse that lasts one internal clock cycle. Two writes in a row give two pulses.
- R5: A cycle in which `bus_ce_n` and `bus_we_n` go low while `bus_oe_n` is already low produces no pulse.
- R6: If `bus_oe_n` drops while a write is in progress, the write is dropped and no pulse follows.
- R7: With `cfg_sync`=1, a rising edge of `bus_clk` while `bus_avd_n`=0, `bus_ce_n`=0 and `bus_oe_n`=1 latches the bus address. The next write reports that address, even if the bus address changes before write enable falls.
- R8: With `cfg_sync`=0, `bus_clk` and `bus_avd_n` have no effect: the same sequence as in R7 reports the address taken at the write-enable falling edge.
- R9: With `cfg_sync`=1, a write without an address phase behaves as in R2.
- R10: With SYNC_STAGES=2, `wr_valid` is high in the third internal clock cycle after the releasing strobe edge is driven, and low in the second and fourth cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync | input | 1 | 1 = synchronous mode, 0 = asynchronous mode (quasi-static) |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_avd_n | input | 1 | Host address-valid strobe, active low |
| bus_clk | input | 1 | Host bus clock |
| bus_addr | input | ADDR_W | Host address lines |
| bus_data | input | DATA_W | Host data lines |
| wr_valid | output | 1 | One-cycle write transaction strobe |
| wr_addr | output | ADDR_W | Address of the transaction |
| wr_data | output | DATA_W | Data of the transaction |

## Verification
The bench builds the block with its defaults: 16-bit address and data, two synchronizer stages and the synchronous path present. The synchronizer depth of two fixes the strobe at a known cycle, so the exact pulse position can be checked. Because the synchronous path is built, both modes can be exercised on one instance by toggling the configuration input between writes. The variant with the synchronous path left out is not exercised by the bench.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

   // bit positions inside the synchronized control vector
   localparam int CB_CE  = 0;
   localparam int CB_WE  = 1;
   localparam int CB_OE  = 2;
   localparam int CB_AVD = 3;
   localparam int CB_CLK = 4;
   localparam int CTL_W  = 5;

   // idle values of the control pins (strobes high, host clock low)
   localparam logic [CTL_W-1:0] CTL_IDLE = 5'b01111;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_ARMED = 2'd1,
      WS_DROP  = 2'd2
   } wr_state_e;

endpackage

// File: rtl/fwl_sync.sv
module fwl_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fwl_wr_ctl.sv
module fwl_wr_ctl
   import flash_wr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   input  logic oe_n,
   output logic load_addr,
   output logic load_data,
   output logic fire
);

   wr_state_e st_q, st_d;
   logic      sel;

   assign sel = !ce_n && !we_n;

   always_comb begin
      st_d      = st_q;
      load_addr = 1'b0;
      load_data = 1'b0;
      fire      = 1'b0;
      unique case (st_q)
         WS_IDLE: begin
            if (sel) begin
               if (oe_n) begin
                  st_d      = WS_ARMED;
                  load_addr = 1'b1;   // later falling edge reached
                  load_data = 1'b1;
               end else begin
                  st_d = WS_DROP;     // output enable low: not a write
               end
            end
         end
         WS_ARMED: begin
            if (!oe_n) begin
               st_d = WS_DROP;
            end else if (sel) begin
               load_data = 1'b1;      // keep tracking the data lines
            end else begin
               fire = 1'b1;           // first rising edge reached
               st_d = WS_IDLE;
            end
         end
         WS_DROP: begin
            if (!sel) st_d = WS_IDLE;
         end
         default: st_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= WS_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/fwl_addr_latch.sv
module fwl_addr_latch #(
   parameter int ADDR_W  = 16,
   parameter bit SYNC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sync,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              avd_n,
   input  logic              bclk,
   input  logic [ADDR_W-1:0] addr,
   input  logic              load_async,
   input  logic              consume,
   output logic [ADDR_W-1:0] addr_out,
   output logic              sync_hit
);

   logic [ADDR_W-1:0] async_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          async_q <= '0;
      else if (load_async) async_q <= addr;
   end

   if (SYNC_EN) begin : g_sync
      logic              bclk_d;
      logic              sync_vld;
      logic [ADDR_W-1:0] sync_q;

      assign sync_hit = cfg_sync && !avd_n && !ce_n && oe_n && bclk && !bclk_d;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bclk_d   <= 1'b0;
            sync_vld <= 1'b0;
            sync_q   <= '0;
         end else begin
            bclk_d <= bclk;
            if (sync_hit) begin
               sync_vld <= 1'b1;
               sync_q   <= addr;
            end else if (consume || ce_n) begin
               sync_vld <= 1'b0;
            end
         end
      end

      assign addr_out = sync_vld ? sync_q : async_q;
   end else begin : g_async_only
      logic unused_sync_pins;
      assign unused_sync_pins = ^{cfg_sync, ce_n, oe_n, avd_n, bclk, consume};
      assign sync_hit = 1'b0;
      assign addr_out = async_q;
   end

endmodule

// File: rtl/flash_wr_latch.sv
module flash_wr_latch
   import flash_wr_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit SYNC_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sync,
   input  logic              bus_ce_n,
   input  logic              bus_we_n,
   input  logic              bus_oe_n,
   input  logic              bus_avd_n,
   input  logic              bus_clk,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam int BUS_W = ADDR_W + DATA_W;

   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("flash_wr_latch: ADDR_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("flash_wr_latch: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("flash_wr_latch: SYNC_STAGES must be at least 2");
   end

   logic [CTL_W-1:0]  ctl_raw, ctl_s;
   logic [BUS_W-1:0]  bus_raw, bus_s;
   logic              s_ce_n, s_we_n, s_oe_n, s_avd_n, s_bclk;
   logic [ADDR_W-1:0] s_addr, addr_sel;
   logic [DATA_W-1:0] s_data, data_q;
   logic              load_addr, load_data, fire, sync_hit;

   always_comb begin
      ctl_raw         = '0;
      ctl_raw[CB_CE]  = bus_ce_n;
      ctl_raw[CB_WE]  = bus_we_n;
      ctl_raw[CB_OE]  = bus_oe_n;
      ctl_raw[CB_AVD] = bus_avd_n;
      ctl_raw[CB_CLK] = bus_clk;
   end
   assign bus_raw = {bus_addr, bus_data};

   fwl_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s));

   fwl_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b0}})) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s));

   assign s_ce_n  = ctl_s[CB_CE];
   assign s_we_n  = ctl_s[CB_WE];
   assign s_oe_n  = ctl_s[CB_OE];
   assign s_avd_n = ctl_s[CB_AVD];
   assign s_bclk  = ctl_s[CB_CLK];
   assign s_addr  = bus_s[BUS_W-1:DATA_W];
   assign s_data  = bus_s[DATA_W-1:0];

   fwl_wr_ctl u_ctl (
      .clk(clk), .rst_n(rst_n),
      .ce_n(s_ce_n), .we_n(s_we_n), .oe_n(s_oe_n),
      .load_addr(load_addr), .load_data(load_data), .fire(fire));

   fwl_addr_latch #(.ADDR_W(ADDR_W), .SYNC_EN(SYNC_EN)) u_addr (
      .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync),
      .ce_n(s_ce_n), .oe_n(s_oe_n), .avd_n(s_avd_n), .bclk(s_bclk),
      .addr(s_addr), .load_async(load_addr), .consume(fire),
      .addr_out(addr_sel), .sync_hit(sync_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         data_q <= '0;
      else if (load_data) data_q <= s_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= fire;
         if (fire) begin
            wr_addr <= addr_sel;
            wr_data <= data_q;
         end
      end
   end

endmodule

// File: rtl/flash_wr_latch_chk.sv
module flash_wr_latch_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_sync,
   input logic wr_valid,
   input logic s_ce_n,
   input logic s_we_n,
   input logic s_oe_n,
   input logic sync_hit
);

   // R4: a transaction strobe never lasts more than one cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   // R4: the strobe follows a cycle where both strobes were low
   a_r4_from_selected: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(!s_ce_n && !s_we_n, 2));

   // R3: the strobe follows a release of enable or write enable
   a_r3_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(s_ce_n || s_we_n));

   // R5 and R6: output enable was high when the write completed
   a_r5_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(s_oe_n));

   // R8: asynchronous configuration never takes an address phase
   a_r8_no_sync_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_sync |-> !sync_hit);

endmodule

bind flash_wr_latch flash_wr_latch_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .wr_valid(wr_valid),
   .s_ce_n(s_ce_n), .s_we_n(s_we_n), .s_oe_n(s_oe_n), .sync_hit(sync_hit));

// File: tb/sim_flash_wr_latch.sv
module sim_flash_wr_latch;

   typedef struct packed {
      logic        cfg;
      logic [2:0]  kind;   // 0 CE first, 1 WE first, 2 address phase, 3 OE low, 4 OE drop
      logic [15:0] a1, a2, d1, d2;
      logic [1:0]  npulse;
      logic [15:0] ea, ed;
      logic [3:0]  areq;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'd0, 16'h1111, 16'h2222, 16'hAAAA, 16'h5555, 2'd1, 16'h2222, 16'hAAAA, 4'd2}, // R2 R3
      '{1'b0, 3'd1, 16'h3333, 16'h4444, 16'h0F0F, 16'hF0F0, 2'd1, 16'h4444, 16'h0F0F, 4'd2}, // R2 R3
      '{1'b0, 3'd2, 16'h1234, 16'h5678, 16'hBEEF, 16'h0000, 2'd1, 16'h5678, 16'hBEEF, 4'd8}, // R8
      '{1'b1, 3'd2, 16'h1234, 16'h5678, 16'hCAFE, 16'h1111, 2'd1, 16'h1234, 16'hCAFE, 4'd7}, // R7
      '{1'b1, 3'd0, 16'h0101, 16'h0202, 16'h7777, 16'h8888, 2'd1, 16'h0202, 16'h7777, 4'd9}, // R9
      '{1'b0, 3'd3, 16'h0A0A, 16'h0B0B, 16'h0C0C, 16'h0D0D, 2'd0, 16'h0000, 16'h0000, 4'd5}, // R5
      '{1'b1, 3'd4, 16'h0E0E, 16'h0F0F, 16'h1010, 16'h2020, 2'd0, 16'h0000, 16'h0000, 4'd6}, // R6
      '{1'b1, 3'd1, 16'hABCD, 16'hDCBA, 16'h1357, 16'h2468, 2'd1, 16'hDCBA, 16'h1357, 4'd9}  // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_sync = 1'b0;
   logic        bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1, bus_avd_n = 1'b1, bus_clk = 1'b0;
   logic [15:0] bus_addr = '0, bus_data = '0;
   logic        wr_valid;
   logic [15:0] wr_addr, wr_data;

   int checks = 0, failures = 0, pulses = 0;
   logic [15:0] got_a = '0, got_d = '0;

   always #5 clk = ~clk;

   flash_wr_latch u0 (
      .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync),
      .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
      .bus_avd_n(bus_avd_n), .bus_clk(bus_clk),
      .bus_addr(bus_addr), .bus_data(bus_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         pulses = pulses + 1;
         got_a  = wr_addr;
         got_d  = wr_data;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_write(input logic [2:0] kind, input logic [15:0] a1, a2, d1, d2);
      bus_addr = a1; bus_data = d1;
      case (kind)
         3'd0: begin
            bus_ce_n = 0; idle(4); bus_addr = a2; bus_we_n = 0; idle(4);
            bus_we_n = 1; idle(1); bus_data = d2; idle(4); bus_ce_n = 1;
         end
         3'd1: begin
            bus_we_n = 0; idle(4); bus_addr = a2; bus_ce_n = 0; idle(4);
            bus_ce_n = 1; idle(1); bus_data = d2; idle(4); bus_we_n = 1;
         end
         3'd2: begin
            bus_avd_n = 0; bus_ce_n = 0; idle(3); bus_clk = 1; idle(4);
            bus_clk = 0; bus_avd_n = 1; bus_addr = a2; idle(3); bus_we_n = 0; idle(4);
            bus_we_n = 1; idle(1); bus_data = d2; idle(4); bus_ce_n = 1;
         end
         3'd3: begin
            bus_oe_n = 0; idle(2); bus_ce_n = 0; bus_we_n = 0; idle(5);
            bus_we_n = 1; bus_ce_n = 1; idle(3); bus_oe_n = 1;
         end
         default: begin
            bus_ce_n = 0; bus_we_n = 0; idle(5); bus_oe_n = 0; idle(3);
            bus_we_n = 1; bus_ce_n = 1; idle(3); bus_oe_n = 1;
         end
      endcase
      idle(8);
   endtask

   bit done = 0;

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      idle(3);
      chk(wr_valid == 0, "R1", {31'b0, wr_valid}, 0);
      chk(wr_addr == 0 && wr_data == 0, "R1", {wr_addr, wr_data}, 0);
      rst_n = 1; idle(4);
      chk(wr_valid == 0 && pulses == 0, "R1", pulses, 0);

      for (int i = 0; i < NV; i++) begin
         cfg_sync = VECS[i].cfg;
         idle(2);
         pulses = 0;
         run_write(VECS[i].kind, VECS[i].a1, VECS[i].a2, VECS[i].d1, VECS[i].d2);
         chk(pulses == VECS[i].npulse, "R4 pulse count", pulses, VECS[i].npulse);
         if (VECS[i].npulse != 0) begin
            chk(got_a == VECS[i].ea, $sformatf("R%0d address", VECS[i].areq), got_a, VECS[i].ea);
            chk(got_d == VECS[i].ed, "R3 data", got_d, VECS[i].ed);
         end
      end

      // R10: exact strobe cycle after the releasing edge
      cfg_sync = 0; pulses = 0;
      bus_addr = 16'h4242; bus_data = 16'h9999;
      bus_ce_n = 0; bus_we_n = 0; idle(5);
      bus_we_n = 1;
      @(negedge clk); chk(wr_valid == 0, "R10 cycle1", {31'b0, wr_valid}, 0);
      @(negedge clk); chk(wr_valid == 0, "R10 cycle2", {31'b0, wr_valid}, 0);
      @(negedge clk); chk(wr_valid == 1, "R10 cycle3", {31'b0, wr_valid}, 1);
      @(negedge clk); chk(wr_valid == 0, "R10 cycle4", {31'b0, wr_valid}, 0);
      bus_ce_n = 1; idle(6);
      chk(got_a == 16'h4242 && got_d == 16'h9999, "R2 R3 latency write", {got_a, got_d}, 32'h42429999);

      // R4: two writes back to back give two pulses
      pulses = 0;
      run_write(3'd0, 16'h0001, 16'h0002, 16'h0003, 16'h0004);
      run_write(3'd1, 16'h0005, 16'h0006, 16'h0007, 16'h0008);
      chk(pulses == 2, "R4 back to back", pulses, 2);
      chk(got_a == 16'h0006 && got_d == 16'h0007, "R4 last txn", {got_a, got_d}, 32'h00060007);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule